// File: doc/BRIEF.md
# Memory-Mapped Integer Divider

This block is a divider peripheral on a simple 32-bit register bus. The bus has a write strobe, a read strobe, a byte address, write data and read data. Software first stores a dividend in one register. It then writes a divisor to a second register, and that write alone starts an unsigned division. An internal engine produces one quotient bit per clock. When the engine is done, the quotient and the remainder are latched into two result registers and a finish bit in a status register is set.

A zero divisor does not stall the engine. It completes on the next clock with a dedicated status bit set, an all-ones quotient and the dividend's low bits as the remainder. A new divisor write during a running division abandons that division and starts over. The widths of the dividend and the divisor are parameters. The bus is always 32 bits wide, and any register bits above a field's width read as zero.

Top module: `mmio_divider`

## Requirements
- R1: After reset, every mapped register (byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10) reads 0.
- R2: Offset 0x00 holds the dividend in bits DVD_W-1:0. It can be read back, and bits above DVD_W-1 read 0.
- R3: Offset 0x04 holds the divisor in bits DVS_W-1:0 and reads back with its upper bits 0. Every bus write to 0x04 starts a division using the dividend register's current value.
- R4: Status bit 0 (finish) reads 0 from the clock edge that captures a divisor write. With a nonzero divisor, it reads 1 exactly DVD_W clock edges later.
- R5: Once finish is set after a nonzero divisor, offset 0x08 reads floor(dividend/divisor) and offset 0x0C reads dividend mod divisor in bits DVS_W-1:0.
- R6: A zero divisor sets finish one edge after the write, together with status bit 1 (divide-by-zero). The quotient then reads all ones over DVD_W bits and the remainder reads the dividend's low DVS_W bits. Status bit 1 reads 0 after a nonzero divisor, and it is never 1 while finish is 0.
- R7: A divisor write during a running division abandons it. Finish stays 0 until DVD_W edges after the latest write, and the result uses the new divisor.
- R8: Writing the dividend register while a division runs does not change that division's result.
- R9: Writes to offsets 0x08, 0x0C and 0x10 leave the quotient, remainder and status values unchanged.
- R10: Reads of offsets 0x14 to 0x1C, or of any address with bits 1:0 nonzero, return 0, and writes to such addresses have no effect. When the read strobe is low, read data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe, one register write per cycle |
| bus_re | input | 1 | Read strobe, gates read data |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address and strobe |

## Verification
The bench builds the block with an 8-bit dividend and a 4-bit divisor on the full 32-bit bus. With these widths, every one of the 4096 dividend/divisor pairs can be run, zero divisor included, and the results are compared against arithmetic done in the bench. The narrow fields also leave most of every 32-bit register unused, so the zeroing of the upper read bits is checked on each access. The short latency of eight cycles keeps the timed restart and write-during-run cases brief enough to check edge by edge.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;

   localparam int unsigned BUS_W  = 32;
   localparam int unsigned ADDR_W = 5;

   // word index = byte address bits 4:2
   localparam logic [2:0] WSEL_DVD  = 3'd0;
   localparam logic [2:0] WSEL_DVS  = 3'd1;
   localparam logic [2:0] WSEL_QUO  = 3'd2;
   localparam logic [2:0] WSEL_REM  = 3'd3;
   localparam logic [2:0] WSEL_STAT = 3'd4;

   localparam int unsigned STAT_FIN_BIT = 0;
   localparam int unsigned STAT_DZ_BIT  = 1;

   typedef enum logic [1:0] {
      ENG_IDLE = 2'd0,
      ENG_RUN  = 2'd1,
      ENG_ZERO = 2'd2
   } eng_state_e;

endpackage

// File: rtl/mdiv_zext.sv
module mdiv_zext #(
   parameter int unsigned IN_W  = 16,
   parameter int unsigned OUT_W = 32
) (
   input  logic [IN_W-1:0]  in_i,
   output logic [OUT_W-1:0] out_o
);

   generate
      if (IN_W == OUT_W) begin : g_same
         assign out_o = in_i;
      end else begin : g_pad
         assign out_o = {{(OUT_W - IN_W){1'b0}}, in_i};
      end
   endgenerate

endmodule

// File: rtl/mdiv_engine.sv
module mdiv_engine
   import mdiv_pkg::*;
#(
   parameter int unsigned DVD_W = 32,
   parameter int unsigned DVS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [DVD_W-1:0] dvd_i,
   input  logic [DVS_W-1:0] dvs_i,
   output logic             done_o,
   output logic [DVD_W-1:0] quo_o,
   output logic [DVS_W-1:0] rem_o,
   output logic             zero_o
);

   localparam int unsigned CNT_W = $clog2(DVD_W + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DVD_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

   eng_state_e       state_q;
   logic [DVD_W-1:0] q_q;
   logic [DVS_W-1:0] r_q;
   logic [DVS_W-1:0] d_q;
   logic [CNT_W-1:0] cnt_q;

   logic [DVS_W:0]   trial;
   logic [DVS_W:0]   diff;
   logic             take;
   logic [DVS_W-1:0] r_nxt;
   logic [DVD_W-1:0] q_nxt;

   // one restoring step: shift in the next dividend bit, subtract if it fits
   always_comb begin
      trial = {r_q, q_q[DVD_W-1]};
      diff  = trial - {1'b0, d_q};
      take  = (trial >= {1'b0, d_q});
      r_nxt = take ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
      q_nxt = {q_q[DVD_W-2:0], take};
   end

   always_comb begin
      done_o = 1'b0;
      zero_o = 1'b0;
      quo_o  = q_nxt;
      rem_o  = r_nxt;
      if (state_q == ENG_ZERO) begin
         done_o = 1'b1;
         zero_o = 1'b1;
         quo_o  = '1;
         rem_o  = q_q[DVS_W-1:0];
      end else if (state_q == ENG_RUN && cnt_q == CNT_LAST) begin
         done_o = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         q_q     <= '0;
         r_q     <= '0;
         d_q     <= '0;
         cnt_q   <= '0;
      end else if (start_i) begin
         q_q     <= dvd_i;
         r_q     <= '0;
         d_q     <= dvs_i;
         cnt_q   <= CNT_LOAD;
         state_q <= (dvs_i == '0) ? ENG_ZERO : ENG_RUN;
      end else begin
         unique case (state_q)
            ENG_RUN: begin
               q_q   <= q_nxt;
               r_q   <= r_nxt;
               cnt_q <= cnt_q - CNT_LAST;
               if (cnt_q == CNT_LAST) state_q <= ENG_IDLE;
            end
            ENG_ZERO: state_q <= ENG_IDLE;
            default:  state_q <= ENG_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mdiv_regs.sv
module mdiv_regs
   import mdiv_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DVD_W  = 32,
   parameter int unsigned DVS_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic              re_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              start_o,
   output logic [DVD_W-1:0]  dvd_o,
   output logic [DVS_W-1:0]  dvs_o,
   input  logic              done_i,
   input  logic [DVD_W-1:0]  quo_i,
   input  logic [DVS_W-1:0]  rem_i,
   input  logic              zero_i,
   output logic              fin_o,
   output logic              dz_o
);

   logic [2:0]       word;
   logic             aligned;
   logic             wr_dvd;
   logic [DVD_W-1:0] dvd_q;
   logic [DVS_W-1:0] dvs_q;
   logic [DVD_W-1:0] quo_q;
   logic [DVS_W-1:0] rem_q;
   logic             fin_q;
   logic             dz_q;

   logic [DATA_W-1:0] dvd_x;
   logic [DATA_W-1:0] dvs_x;
   logic [DATA_W-1:0] quo_x;
   logic [DATA_W-1:0] rem_x;

   assign word    = addr_i[ADDR_W-1:2];
   assign aligned = (addr_i[1:0] == 2'b00);
   assign wr_dvd  = we_i && aligned && (word == WSEL_DVD);
   assign start_o = we_i && aligned && (word == WSEL_DVS);
   assign dvd_o   = dvd_q;
   assign dvs_o   = wdata_i[DVS_W-1:0];
   assign fin_o   = fin_q;
   assign dz_o    = dz_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dvd_q <= '0;
         dvs_q <= '0;
         quo_q <= '0;
         rem_q <= '0;
         fin_q <= 1'b0;
         dz_q  <= 1'b0;
      end else begin
         if (wr_dvd) dvd_q <= wdata_i[DVD_W-1:0];
         if (start_o) begin
            dvs_q <= wdata_i[DVS_W-1:0];
            fin_q <= 1'b0;
            dz_q  <= 1'b0;
         end else if (done_i) begin
            quo_q <= quo_i;
            rem_q <= rem_i;
            fin_q <= 1'b1;
            dz_q  <= zero_i;
         end
      end
   end

   mdiv_zext #(.IN_W(DVD_W), .OUT_W(DATA_W)) u_zx_dvd (.in_i(dvd_q), .out_o(dvd_x));
   mdiv_zext #(.IN_W(DVS_W), .OUT_W(DATA_W)) u_zx_dvs (.in_i(dvs_q), .out_o(dvs_x));
   mdiv_zext #(.IN_W(DVD_W), .OUT_W(DATA_W)) u_zx_quo (.in_i(quo_q), .out_o(quo_x));
   mdiv_zext #(.IN_W(DVS_W), .OUT_W(DATA_W)) u_zx_rem (.in_i(rem_q), .out_o(rem_x));

   always_comb begin
      rdata_o = '0;
      if (re_i && aligned) begin
         case (word)
            WSEL_DVD:  rdata_o = dvd_x;
            WSEL_DVS:  rdata_o = dvs_x;
            WSEL_QUO:  rdata_o = quo_x;
            WSEL_REM:  rdata_o = rem_x;
            WSEL_STAT: begin
               rdata_o[STAT_FIN_BIT] = fin_q;
               rdata_o[STAT_DZ_BIT]  = dz_q;
            end
            default:   rdata_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/mmio_divider.sv
module mmio_divider
   import mdiv_pkg::*;
#(
   parameter int unsigned DATA_W = BUS_W,
   parameter int unsigned DVD_W  = 32,
   parameter int unsigned DVS_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);

   generate
      if (DVD_W < 2) begin : g_bad_dvd
         $error("mmio_divider: DVD_W must be at least 2");
      end
      if (DVS_W > DVD_W) begin : g_bad_dvs
         $error("mmio_divider: DVS_W must not exceed DVD_W");
      end
      if (DVD_W > DATA_W) begin : g_bad_bus
         $error("mmio_divider: DVD_W must fit the bus");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("mmio_divider: DATA_W must hold the status bits");
      end
   endgenerate

   logic             div_start;
   logic [DVD_W-1:0] div_dvd;
   logic [DVS_W-1:0] div_dvs;
   logic             eng_done;
   logic [DVD_W-1:0] eng_quo;
   logic [DVS_W-1:0] eng_rem;
   logic             eng_zero;
   logic             stat_fin;
   logic             stat_dz;

   mdiv_regs #(
      .DATA_W(DATA_W),
      .DVD_W (DVD_W),
      .DVS_W (DVS_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (bus_we),
      .re_i   (bus_re),
      .addr_i (bus_addr),
      .wdata_i(bus_wdata),
      .rdata_o(bus_rdata),
      .start_o(div_start),
      .dvd_o  (div_dvd),
      .dvs_o  (div_dvs),
      .done_i (eng_done),
      .quo_i  (eng_quo),
      .rem_i  (eng_rem),
      .zero_i (eng_zero),
      .fin_o  (stat_fin),
      .dz_o   (stat_dz)
   );

   mdiv_engine #(
      .DVD_W(DVD_W),
      .DVS_W(DVS_W)
   ) u_engine (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(div_start),
      .dvd_i  (div_dvd),
      .dvs_i  (div_dvs),
      .done_o (eng_done),
      .quo_o  (eng_quo),
      .rem_o  (eng_rem),
      .zero_o (eng_zero)
   );

endmodule

// File: rtl/mmio_divider_chk.sv
module mmio_divider_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DVD_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic              bus_re,
   input logic [4:0]        bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              start,
   input logic              fin,
   input logic              dz,
   input logic              done
);

   localparam int unsigned LIM    = DVD_W + 2;
   localparam int unsigned SINCE_W = $clog2(LIM + 1);
   localparam logic [SINCE_W-1:0] LAT_RUN  = SINCE_W'(DVD_W + 1);
   localparam logic [SINCE_W-1:0] LAT_ZERO = SINCE_W'(2);

   logic [SINCE_W-1:0] since;

   // edges since the latest divisor write, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  since <= '0;
      else if (start)                              since <= SINCE_W'(1);
      else if (since != '0 && since < SINCE_W'(LIM)) since <= since + SINCE_W'(1);
   end

   a_r10_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |-> bus_rdata == '0);

   a_r4_start_clears_fin: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !fin);

   a_r4_finish_latency: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(fin) && !dz) |-> since == LAT_RUN);

   a_r6_zero_latency: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(fin) && dz) |-> since == LAT_ZERO);

   a_r6_dz_implies_fin: assert property (@(posedge clk) disable iff (!rst_n)
      dz |-> fin);

   a_r9_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 5'h10 && !done) |=> ($stable(fin) && $stable(dz)));

endmodule

bind mmio_divider mmio_divider_chk #(
   .DATA_W(DATA_W),
   .DVD_W (DVD_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_we   (bus_we),
   .bus_re   (bus_re),
   .bus_addr (bus_addr),
   .bus_rdata(bus_rdata),
   .start    (div_start),
   .fin      (stat_fin),
   .dz       (stat_dz),
   .done     (eng_done)
);

// File: tb/test_mmio_divider.sv
`timescale 1ns/1ps
module test_mmio_divider;

   localparam int unsigned DVD_W = 8;
   localparam int unsigned DVS_W = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic        re = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   mmio_divider #(.DATA_W(32), .DVD_W(DVD_W), .DVS_W(DVS_W)) i_mmio_divider (
      .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_re(re),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      addr = a; re = 1'b1;
      #0.1;
      d = rdata;
      re = 1'b0;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);

      // R1 reset state
      for (int a = 0; a <= 16; a += 4) begin
         rd(5'(a), v); chk("R1 reset value", v, 32'h0);
      end

      // R2 dividend register, upper bits zero
      wr(5'h00, 32'hFFFF_FFA5);
      rd(5'h00, v); chk("R2 dividend readback", v, 32'h0000_00A5);

      // R3 divisor register, upper bits zero; write starts a division
      wr(5'h04, 32'h1234_567D);
      rd(5'h04, v); chk("R3 divisor readback", v, 32'h0000_000D);
      cyc(DVD_W);
      rd(5'h08, v); chk("R3 write starts division quo", v, 32'(8'hA5 / 8'hD));

      // R5 / R6 exhaustive sweep
      for (int n = 0; n < (1 << DVD_W); n++) begin
         for (int d = 0; d < (1 << DVS_W); d++) begin
            logic [31:0] eq, er, es;
            wr(5'h00, 32'(n));
            wr(5'h04, 32'(d));
            cyc(DVD_W);
            if (d == 0) begin
               eq = 32'hFF; er = 32'(n % 16); es = 32'h3;
            end else begin
               eq = 32'(n / d); er = 32'(n % d); es = 32'h1;
            end
            rd(5'h08, v); chk(d == 0 ? "R6 zero quotient"  : "R5 quotient",  v, eq);
            rd(5'h0C, v); chk(d == 0 ? "R6 zero remainder" : "R5 remainder", v, er);
            rd(5'h10, v); chk(d == 0 ? "R6 zero status"    : "R6 status dz clear", v, es);
         end
      end

      // R4 finish timing
      wr(5'h00, 32'd200);
      wr(5'h04, 32'd7);
      rd(5'h10, v); chk("R4 finish cleared by write", v, 32'h0);
      cyc(DVD_W - 1);
      rd(5'h10, v); chk("R4 finish not early", v, 32'h0);
      cyc(1);
      rd(5'h10, v); chk("R4 finish on time", v, 32'h1);
      rd(5'h08, v); chk("R4 quotient", v, 32'd28);
      rd(5'h0C, v); chk("R4 remainder", v, 32'd4);

      // R6 zero divisor timing
      wr(5'h00, 32'h5B);
      wr(5'h04, 32'h0);
      rd(5'h10, v); chk("R6 status cleared by write", v, 32'h0);
      cyc(1);
      rd(5'h10, v); chk("R6 zero finishes next edge", v, 32'h3);
      rd(5'h08, v); chk("R6 zero quotient ones", v, 32'hFF);
      rd(5'h0C, v); chk("R6 zero remainder low bits", v, 32'hB);

      // R8 dividend write during run
      wr(5'h00, 32'd100);
      wr(5'h04, 32'd3);
      cyc(2);
      wr(5'h00, 32'd50);
      cyc(DVD_W);
      rd(5'h08, v); chk("R8 quotient unaffected", v, 32'd33);
      rd(5'h0C, v); chk("R8 remainder unaffected", v, 32'd1);
      rd(5'h00, v); chk("R8 dividend updated", v, 32'd50);

      // R7 restart mid-run
      wr(5'h04, 32'd3);
      cyc(3);
      wr(5'h04, 32'd6);
      rd(5'h10, v); chk("R7 finish low after restart", v, 32'h0);
      cyc(DVD_W - 1);
      rd(5'h10, v); chk("R7 finish not early", v, 32'h0);
      cyc(1);
      rd(5'h10, v); chk("R7 finish after latest write", v, 32'h1);
      rd(5'h08, v); chk("R7 quotient new divisor", v, 32'd8);
      rd(5'h0C, v); chk("R7 remainder new divisor", v, 32'd2);

      // R9 result/status writes ignored
      wr(5'h08, 32'hFFFF_FFFF);
      wr(5'h0C, 32'hFFFF_FFFF);
      wr(5'h10, 32'hFFFF_FFFF);
      rd(5'h08, v); chk("R9 quotient kept", v, 32'd8);
      rd(5'h0C, v); chk("R9 remainder kept", v, 32'd2);
      rd(5'h10, v); chk("R9 status kept", v, 32'h1);

      // R10 unmapped and misaligned
      wr(5'h14, 32'h1234);
      wr(5'h05, 32'h9);
      rd(5'h14, v); chk("R10 unmapped 0x14", v, 32'h0);
      rd(5'h18, v); chk("R10 unmapped 0x18", v, 32'h0);
      rd(5'h1C, v); chk("R10 unmapped 0x1C", v, 32'h0);
      rd(5'h01, v); chk("R10 misaligned read", v, 32'h0);
      rd(5'h04, v); chk("R10 misaligned write ignored divisor", v, 32'd6);
      rd(5'h10, v); chk("R10 misaligned write no start", v, 32'h1);
      addr = 5'h08; re = 1'b0;
      #0.1;
      chk("R10 read strobe low", rdata, 32'h0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule